// File: doc/BRIEF.md
# Watchdog Timer with Sleep Wake-up

This block is a watchdog that counts edges of its own slow tick clock, not the system clock. It therefore keeps running while the core has stopped its clock for sleep. One of two controls turns it on. The first is a fixed configuration input that software cannot override. The second is a one-bit software control register, which has an effect only while the configuration input is low. A power-of-two postscaler, chosen by a configuration input, stretches the base count so the timeout can be set from 1 to 128 base periods.

What happens at expiry depends on whether the core is asleep. While the core is running, the block sends a one-cycle device reset request. While the core is asleep, it sends a one-cycle wake-up request instead and leaves the sleep state. In both cases the active-low timeout flag drops to 0. The clear command and the sleep command each restart the base count and the postscaler count, and each sets the flag back to 1. Requests pass from the system domain to the tick domain through a four-phase handshake. Expiry events return to the system domain as a synchronised toggle.

Top module: `wdog_wake`

## Requirements
- R1: The timeout is measured in tick-clock edges: with the postscaler set to 1:1, expiry comes 16 ticks after counting restarts, plus a few ticks of synchronisation latency.
- R2: An expiry while the core is not asleep gives a `rst_req` pulse exactly one system-clock cycle long.
- R3: An expiry while the core is asleep (after a `sleep_cmd` strobe) gives a one-cycle `wake_req` pulse and no `rst_req`, and leaves sleep, so the next expiry gives `rst_req`.
- R4: `tmo_flag_n` is 1 after reset and after any `clr_cmd` or `sleep_cmd` strobe, and it drops to 0 in the cycle an expiry pulse is issued.
- R5: When `cfg_en` is 1, the watchdog counts and expires whatever value is written to the control register.
- R6: When `cfg_en` is 0, control bit 0 set to 1 enables the watchdog and set to 0 stops it, and no expiry occurs while it is stopped.
- R7: `ctl_rdata` is 8'h00 after reset. A write stores `ctl_wdata[0]` in bit 0, and bits 7 to 1 always read 0.
- R8: Both `clr_cmd` and `sleep_cmd` restart the base and postscaler counts, so strobing either one more often than the timeout prevents expiry.
- R9: `ps_sel` value k selects a timeout of 16·2^k ticks, for k from 0 to 7. Clearing the counts leaves the selected ratio in force.
- R10: After an expiry the count restarts from zero with no command, so expiries repeat every timeout period while the block stays enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick_clk | input | 1 | Free-running watchdog tick clock |
| cfg_en | input | 1 | Fixed configuration enable; forces the watchdog on |
| ps_sel | input | 3 | Postscaler select, ratio 2^ps_sel |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data (bit 0 used) |
| ctl_rdata | output | 8 | Control register read data |
| clr_cmd | input | 1 | Clear-watchdog command strobe |
| sleep_cmd | input | 1 | Sleep command strobe; also clears the counts |
| rst_req | output | 1 | One-cycle device reset request |
| wake_req | output | 1 | One-cycle wake-up request |
| tmo_flag_n | output | 1 | Active-low timeout status flag |

## Verification
The bench checks that a configuration enable of 1 keeps the watchdog counting after software writes a 0. A design that gated the count by the software bit alone would never fire in that case. It also checks that an expiry during sleep raises a wake request instead of a reset, and that sleep then ends: a design that kept the sleep state would answer every later expiry with a wake request. It strobes both clear and sleep at half the timeout to show that either command keeps the watchdog from expiring. It also measures the timeout at several postscaler settings, so a ratio decoded off by one power of two shows up as a timeout of the wrong length.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CTL_W = 8;

  function automatic logic [CTL_W-1:0] ctl_view(input logic en_bit);
    ctl_view = {{(CTL_W-1){1'b0}}, en_bit};
  endfunction
endpackage

// File: rtl/wdog_sync.sv
module wdog_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= {STAGES{RST_VAL}};
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/wdog_clr_req.sv
module wdog_clr_req (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  input  logic ack_s,
  output logic req
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      req  <= 1'b0;
      pend <= 1'b0;
    end else if (!req && !ack_s && (pend || kick)) begin
      req  <= 1'b1;
      pend <= 1'b0;
    end else begin
      if (req && ack_s) req <= 1'b0;
      // a kick in the return phase must start a fresh handshake
      if (kick && !req) pend <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_tick_core.sv
module wdog_tick_core #(
  parameter int BASE_W = 4,
  parameter int PS_W   = 3
) (
  input  logic            tick_clk,
  input  logic            tick_rst,
  input  logic            run,
  input  logic            hold,
  input  logic [PS_W-1:0] ps_sel,
  output logic            exp_tgl
);
  localparam int POST_W = (1 << PS_W) - 1;

  logic [BASE_W-1:0] base_q;
  logic [POST_W-1:0] post_q;
  logic [POST_W-1:0] post_last;
  logic              expire;

  always_comb begin
    post_last = POST_W'((32'd1 << ps_sel) - 32'd1);
    expire    = run && !hold && (&base_q) && (post_q == post_last);
  end

  always_ff @(posedge tick_clk) begin
    if (tick_rst) begin
      base_q  <= '0;
      post_q  <= '0;
      exp_tgl <= 1'b0;
    end else if (!run || hold) begin
      base_q <= '0;
      post_q <= '0;
    end else if (expire) begin
      base_q  <= '0;
      post_q  <= '0;
      exp_tgl <= ~exp_tgl;
    end else begin
      base_q <= base_q + 1'b1;
      if (&base_q) post_q <= post_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_wake.sv
module wdog_wake
  import wdog_pkg::*;
#(
  parameter int BASE_W      = 4,
  parameter int PS_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_clk,
  input  logic             cfg_en,
  input  logic [PS_W-1:0]  ps_sel,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             clr_cmd,
  input  logic             sleep_cmd,
  output logic             rst_req,
  output logic             wake_req,
  output logic             tmo_flag_n
);
  logic sw_en, asleep, run_sys, kick;
  logic tick_rst, run_t, req, req_t, ack_s;
  logic exp_tgl, exp_s, exp_d, exp_evt;

  assign run_sys = cfg_en | sw_en;
  assign kick    = clr_cmd | sleep_cmd;
  assign exp_evt = exp_s ^ exp_d;

  wdog_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rst_sync (
    .clk(tick_clk), .rst(1'b0), .d(rst), .q(tick_rst));
  wdog_sync #(.STAGES(SYNC_STAGES)) u_run_sync (
    .clk(tick_clk), .rst(tick_rst), .d(run_sys), .q(run_t));
  wdog_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(tick_clk), .rst(tick_rst), .d(req), .q(req_t));
  wdog_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst(rst), .d(req_t), .q(ack_s));
  wdog_sync #(.STAGES(SYNC_STAGES)) u_exp_sync (
    .clk(clk), .rst(rst), .d(exp_tgl), .q(exp_s));

  wdog_clr_req u_clr_req (
    .clk(clk), .rst(rst), .kick(kick), .ack_s(ack_s), .req(req));

  wdog_tick_core #(.BASE_W(BASE_W), .PS_W(PS_W)) u_core (
    .tick_clk(tick_clk), .tick_rst(tick_rst), .run(run_t), .hold(req_t),
    .ps_sel(ps_sel), .exp_tgl(exp_tgl));

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_en      <= 1'b0;
      asleep     <= 1'b0;
      exp_d      <= 1'b0;
      rst_req    <= 1'b0;
      wake_req   <= 1'b0;
      tmo_flag_n <= 1'b1;
    end else begin
      exp_d    <= exp_s;
      rst_req  <= 1'b0;
      wake_req <= 1'b0;
      if (ctl_wr)    sw_en      <= ctl_wdata[0];
      if (kick)      tmo_flag_n <= 1'b1;
      if (sleep_cmd) asleep     <= 1'b1;
      if (exp_evt) begin
        tmo_flag_n <= 1'b0;
        if (asleep) begin
          wake_req <= 1'b1;
          asleep   <= 1'b0;
        end else begin
          rst_req <= 1'b1;
        end
      end
    end
  end

  assign ctl_rdata = ctl_view(sw_en);
endmodule

// File: rtl/wdog_wake_chk.sv
module wdog_wake_chk (
  input logic       clk,
  input logic       rst,
  input logic       ctl_wr,
  input logic [7:0] ctl_wdata,
  input logic [7:0] ctl_rdata,
  input logic       clr_cmd,
  input logic       sleep_cmd,
  input logic       rst_req,
  input logic       wake_req,
  input logic       tmo_flag_n
);
  // R2
  rst_single_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);
  // R3
  wake_single_chk: assert property (@(posedge clk) disable iff (rst)
    wake_req |=> !wake_req);
  // R4
  flag_low_chk: assert property (@(posedge clk) disable iff (rst)
    (rst_req || wake_req) |-> !tmo_flag_n);
  // R4
  flag_set_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tmo_flag_n) |-> $past(clr_cmd || sleep_cmd));
  // R7
  ctl_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_rdata[7:1] == 7'd0);
  // R7
  ctl_store_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> ctl_rdata[0] == $past(ctl_wdata[0]));
endmodule

bind wdog_wake wdog_wake_chk u_chk (
  .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .ctl_rdata(ctl_rdata), .clr_cmd(clr_cmd), .sleep_cmd(sleep_cmd),
  .rst_req(rst_req), .wake_req(wake_req), .tmo_flag_n(tmo_flag_n));

// File: tb/wdog_wake_tb.sv
module wdog_wake_tb_top;
  localparam int CLK_PERIOD  = 10;
  localparam int TICK_PERIOD = 46;
  localparam int BASE_N      = 16;

  logic       clk = 1'b0, tick_clk = 1'b0, rst = 1'b1;
  logic       cfg_en = 1'b0, ctl_wr = 1'b0, clr_cmd = 1'b0, sleep_cmd = 1'b0;
  logic [2:0] ps_sel = 3'd0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic       rst_req, wake_req, tmo_flag_n;

  int checks = 0, errors = 0, tick_cnt = 0;

  always #(CLK_PERIOD/2)  clk = ~clk;
  always #(TICK_PERIOD/2) tick_clk = ~tick_clk;
  always @(posedge tick_clk) tick_cnt <= tick_cnt + 1;

  wdog_wake dut_i (
    .clk(clk), .rst(rst), .tick_clk(tick_clk), .cfg_en(cfg_en),
    .ps_sel(ps_sel), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .clr_cmd(clr_cmd), .sleep_cmd(sleep_cmd),
    .rst_req(rst_req), .wake_req(wake_req), .tmo_flag_n(tmo_flag_n));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic write_ctl(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic strobe_clr();
    @(negedge clk); clr_cmd = 1'b1;
    @(negedge clk); clr_cmd = 1'b0;
  endtask

  task automatic strobe_sleep();
    @(negedge clk); sleep_cmd = 1'b1;
    @(negedge clk); sleep_cmd = 1'b0;
  endtask

  task automatic quiet();
    cfg_en = 1'b0;
    write_ctl(8'h00);
    repeat (12) @(posedge tick_clk);
    @(negedge clk);
  endtask

  // kind: 0 none, 1 reset request, 2 wake request
  task automatic wait_evt(input int t0, input int max_ticks,
                          output int ticks, output int kind, output int width);
    kind = 0; width = 0; ticks = 0;
    while (tick_cnt - t0 < max_ticks) begin
      @(negedge clk);
      if (rst_req || wake_req) begin
        ticks = tick_cnt - t0;
        kind  = rst_req ? 1 : 2;
        if (rst_req && wake_req) kind = 3;
        while (rst_req || wake_req) begin
          width++;
          @(negedge clk);
        end
        return;
      end
    end
  endtask

  task automatic t_reset();
    check(ctl_rdata == 8'h00, "R7 reset ctl", ctl_rdata, 0);
    check(tmo_flag_n == 1'b1, "R4 reset flag", tmo_flag_n, 1);
    check(!rst_req && !wake_req, "R2 no pulse at reset", rst_req, 0);
  endtask

  task automatic t_reg();
    write_ctl(8'hFF);
    @(negedge clk);
    check(ctl_rdata == 8'h01, "R7 upper bits zero", ctl_rdata, 1);
    write_ctl(8'hFE);
    @(negedge clk);
    check(ctl_rdata == 8'h00, "R7 bit0 cleared", ctl_rdata, 0);
  endtask

  task automatic t_disabled();
    int t0, tk, kd, w;
    quiet();
    ps_sel = 3'd0;
    t0 = tick_cnt;
    strobe_clr();
    wait_evt(t0, 5*BASE_N, tk, kd, w);
    check(kd == 0, "R6 disabled no expiry", kd, 0);
    check(tmo_flag_n == 1'b1, "R6 flag untouched", tmo_flag_n, 1);
  endtask

  task automatic t_sw_enable();
    int t0, tk, kd, w;
    quiet();
    ps_sel = 3'd0;
    write_ctl(8'h01);
    t0 = tick_cnt;
    strobe_clr();
    wait_evt(t0, 4*BASE_N, tk, kd, w);
    check(kd == 1, "R6 sw enable gives reset", kd, 1);
    check(tk >= BASE_N+1 && tk <= BASE_N+9, "R1 base timeout ticks", tk, BASE_N+5);
    check(w == 1, "R2 pulse width", w, 1);
    check(tmo_flag_n == 1'b0, "R4 flag cleared on expiry", tmo_flag_n, 0);
    strobe_clr();
    @(negedge clk);
    check(tmo_flag_n == 1'b1, "R4 flag set by clear", tmo_flag_n, 1);
  endtask

  task automatic t_repeat();
    int t0, tk, kd, w;
    quiet();
    ps_sel = 3'd0;
    write_ctl(8'h01);
    t0 = tick_cnt;
    strobe_clr();
    wait_evt(t0, 4*BASE_N, tk, kd, w);
    t0 = tick_cnt;
    wait_evt(t0, 4*BASE_N, tk, kd, w);
    check(kd == 1, "R10 second expiry", kd, 1);
    check(tk >= BASE_N-2 && tk <= BASE_N+2, "R10 period", tk, BASE_N);
  endtask

  task automatic t_cfg_force();
    int t0, tk, kd, w;
    quiet();
    ps_sel = 3'd0;
    cfg_en = 1'b1;
    write_ctl(8'h00);
    t0 = tick_cnt;
    strobe_clr();
    repeat (4) @(posedge tick_clk);
    write_ctl(8'h00);
    wait_evt(t0, 4*BASE_N, tk, kd, w);
    check(kd == 1, "R5 config enable overrides sw", kd, 1);
  endtask

  task automatic t_ratio(input int k);
    int t0, tk, kd, w, n;
    quiet();
    ps_sel = 3'(k);
    n = BASE_N << k;
    write_ctl(8'h01);
    t0 = tick_cnt;
    strobe_clr();
    wait_evt(t0, 2*n + 20, tk, kd, w);
    check(kd == 1, "R9 expiry at ratio", kd, 1);
    check(tk >= n+1 && tk <= n+9, "R9 ratio timeout ticks", tk, n+5);
  endtask

  task automatic t_kick_clear();
    int r0;
    quiet();
    ps_sel = 3'd0;
    write_ctl(8'h01);
    strobe_clr();
    r0 = 0;
    for (int i = 0; i < 10; i++) begin
      for (int c = 0; c < BASE_N/2; c++) begin
        @(posedge tick_clk);
        @(negedge clk);
        if (rst_req || wake_req) r0++;
      end
      strobe_clr();
    end
    check(r0 == 0, "R8 periodic clear prevents expiry", r0, 0);
  endtask

  task automatic t_sleep();
    int t0, tk, kd, w, r0;
    quiet();
    ps_sel = 3'd0;
    write_ctl(8'h01);
    strobe_clr();
    repeat (10) @(posedge tick_clk);
    r0 = 0;
    for (int i = 0; i < 8; i++) begin
      strobe_sleep();
      for (int c = 0; c < BASE_N/2; c++) begin
        @(posedge tick_clk);
        @(negedge clk);
        if (rst_req || wake_req) r0++;
      end
    end
    check(r0 == 0, "R8 sleep command prevents expiry", r0, 0);
    check(tmo_flag_n == 1'b1, "R4 flag set by sleep", tmo_flag_n, 1);
    t0 = tick_cnt;
    wait_evt(t0, 4*BASE_N, tk, kd, w);
    check(kd == 2, "R3 expiry in sleep wakes", kd, 2);
    check(w == 1, "R3 wake pulse width", w, 1);
    check(tmo_flag_n == 1'b0, "R4 flag cleared on wake", tmo_flag_n, 0);
    t0 = tick_cnt;
    wait_evt(t0, 4*BASE_N, tk, kd, w);
    check(kd == 1, "R3 after wake next expiry resets", kd, 1);
  endtask

  initial begin
    repeat (40) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_reg();
    t_disabled();
    t_sw_enable();
    t_repeat();
    t_cfg_force();
    t_ratio(0);
    t_ratio(2);
    t_ratio(7);
    t_kick_clear();
    t_sleep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule